// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

The block computes the Montgomery product R = A·B·2^(-NW·W) mod N of three operands that are each NW words of W bits, using a modulus coefficient C = -N^(-1) mod 2^(NW·W) that is computed elsewhere and handed in with the operands. A single multiply-accumulate element is shared in time. It works through 2·NW word steps. In each step it forms, column by column, one word of the product A·B, one word of the quotient Q = (A·B)·C (the low half only) and one word of Q·N. The same step then folds that word into a running sum S = A·B + Q·N and a running trial difference S − N·2^(NW·W). Both carry a single rippling carry or borrow bit. When the last step ends, the final carry and borrow pick either S or S − N·2^(NW·W), and the upper NW words of the chosen value form the result. No separate compare pass is needed.

A reduce-only mode skips the product: the words of A are used directly in place of the words of A·B, so the block returns A·2^(-NW·W) mod N. That mode is used to leave the Montgomery domain.

Operands enter through a valid/ready handshake. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so back-pressure lasts for the whole computation. A source may hold `in_valid` high with its data stable until `in_ready` returns. On completion `done_o` pulses for one cycle and `res_o` holds the result until the next completion.

Top module: `mont_mul`

## Requirements
- R1: Take odd N with A < N and B < N, with `in_reduce`=0 and `in_ncoef` = -N^(-1) mod 2^(NW·W). `res_o` then equals A·B·2^(-NW·W) mod N, fully reduced. Operand word k occupies bits [k·W+W-1 : k·W] of its bus, with word 0 least significant.
- R2: With `in_reduce`=1, `res_o` equals A·2^(-NW·W) mod N, and `in_b` has no effect.
- R3: `in_ready` is high while idle. It is low from the cycle after an accepted transfer until `done_o` is seen. Values offered on the input bus while `in_ready` is low are ignored.
- R4: `done_o` is a one-cycle pulse. It rises exactly 2·NW·(3·NW+1) clock cycles after the accepting edge, and `in_ready` is high in the same cycle.
- R5: `res_o` changes only on the edge that raises `done_o`, and it holds its value between completions.
- R6: After reset, `in_ready`=1, `done_o`=0 and `res_o`=0.
- R7: Each accepted transfer clears all accumulators, the carry and the borrow. Back-to-back operations are therefore independent, whatever operands came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on the input bus are valid |
| in_ready | output | 1 | Block is idle and accepts operands |
| in_a | input | NW·W | Multiplicand A, word 0 in the low bits |
| in_b | input | NW·W | Multiplier B |
| in_n | input | NW·W | Odd modulus N |
| in_ncoef | input | NW·W | Coefficient -N^(-1) mod 2^(NW·W) |
| in_reduce | input | 1 | 1 selects reduce-only mode |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | NW·W | Result, held until the next completion |

## Verification
The hardest case to reach is the final selection. It depends on the last carry of the running sum and the last borrow of the running difference together. The corner where the sum overflows all 2·NW words, so that the carry is set and the borrowed difference must still be chosen, occurs only when both A·B and Q·N are near their maximum. The stimulus forces this with an all-ones modulus and operands of N−1, and reaches the opposite corner with tiny moduli and zero or unit operands. Random odd moduli with random A and B below N fill in between. Each result is compared with a bench-side big-integer model that halves and adds bit by bit.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // Sub-phases of one word step: three column passes, then the add/subtract fold
  typedef enum logic [1:0] {
    PH_AB  = 2'd0,
    PH_Q   = 2'd1,
    PH_QN  = 2'd2,
    PH_FIN = 2'd3
  } mm_phase_e;
endpackage

// File: rtl/mm_mac.sv
module mm_mac #(
  parameter int W    = 8,
  parameter int ACCW = 20
) (
  input  logic [W-1:0]    x,
  input  logic [W-1:0]    y,
  input  logic [ACCW-1:0] acc,
  output logic [ACCW-1:0] sum
);
  always_comb sum = acc + (ACCW'(x) * ACCW'(y));
endmodule

// File: rtl/mm_addsub.sv
module mm_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] ab_w,
  input  logic [W-1:0] qn_w,
  input  logic         cin,
  input  logic [W-1:0] n_w,
  input  logic         bin,
  output logic [W-1:0] s_w,
  output logic         cout,
  output logic [W-1:0] sn_w,
  output logic         bout
);
  logic [W:0] add_full, sub_full;
  always_comb begin
    add_full = {1'b0, ab_w} + {1'b0, qn_w} + {{W{1'b0}}, cin};
    s_w      = add_full[W-1:0];
    cout     = add_full[W];
    sub_full = {1'b0, add_full[W-1:0]} - {1'b0, n_w} - {{W{1'b0}}, bin};
    sn_w     = sub_full[W-1:0];
    bout     = sub_full[W];
  end
endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter int NW = 4,
  localparam int SW = $clog2(2*NW),
  localparam int JW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic [JW-1:0] j,
  output mm_phase_e     ph,
  output logic          j_last,
  output logic          fin_last
);
  always_comb begin
    j_last   = (j == JW'(NW-1));
    fin_last = busy && (ph == PH_FIN) && (step == SW'(2*NW-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      j    <= '0;
      ph   <= PH_AB;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
      j    <= '0;
      ph   <= PH_AB;
    end else if (busy) begin
      if (ph == PH_FIN) begin
        ph <= PH_AB;
        if (step == SW'(2*NW-1)) busy <= 1'b0;
        else                     step <= step + 1'b1;
      end else if (j_last) begin
        j  <= '0;
        ph <= mm_phase_e'(ph + 2'd1);
      end else begin
        j <= j + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mont_mul.sv
module mont_mul
  import mm_pkg::*;
#(
  parameter int W  = 8,
  parameter int NW = 4,
  localparam int SW   = $clog2(2*NW),
  localparam int JW   = $clog2(NW),
  localparam int ACCW = 2*W + JW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [NW*W-1:0] in_a,
  input  logic [NW*W-1:0] in_b,
  input  logic [NW*W-1:0] in_n,
  input  logic [NW*W-1:0] in_ncoef,
  input  logic          in_reduce,
  output logic          done_o,
  output logic [NW*W-1:0] res_o
);
  logic [NW-1:0][W-1:0] a_q, b_q, n_q, c_q;
  logic [NW-1:0][W-1:0] ab_arr, q_arr, s_hi, sn_hi;
  logic                 red_q;
  logic [ACCW-1:0]      acc_ab, acc_q, acc_qn;
  logic [W-1:0]         ab_cur, qn_cur;
  logic                 cy, bw;

  logic busy, j_last, fin_last, accept;
  logic [SW-1:0] step;
  logic [JW-1:0] j;
  mm_phase_e     ph;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  mm_seq #(.NW(NW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .step(step),
    .j(j), .ph(ph), .j_last(j_last), .fin_last(fin_last)
  );

  // Column term selection: x from the word indexed by j, y from index step-j
  logic [SW-1:0]   jx, k;
  logic            in_rng, hi_half;
  logic [JW-1:0]   k_idx, hi_idx;
  logic [W-1:0]    mx, my;
  logic [ACCW-1:0] macc, msum;

  always_comb begin
    jx      = {{(SW-JW){1'b0}}, j};
    k       = step - jx;
    in_rng  = (step >= jx) && (k < SW'(NW));
    k_idx   = k[JW-1:0];
    hi_half = (step >= SW'(NW));
    hi_idx  = JW'(step - SW'(NW));
    mx = '0; my = '0; macc = '0;
    unique case (ph)
      PH_AB:  begin mx = a_q[j];    my = in_rng ? b_q[k_idx] : '0; macc = acc_ab; end
      PH_Q:   begin mx = ab_arr[j]; my = in_rng ? c_q[k_idx] : '0; macc = acc_q;  end
      PH_QN:  begin mx = q_arr[j];  my = in_rng ? n_q[k_idx] : '0; macc = acc_qn; end
      default: ;
    endcase
  end

  mm_mac #(.W(W), .ACCW(ACCW)) u_mac (.x(mx), .y(my), .acc(macc), .sum(msum));

  logic [W-1:0] s_w, sn_w, n_fold, ab_word;
  logic         cout, bout;
  assign n_fold  = hi_half ? n_q[hi_idx] : '0;
  assign ab_word = red_q ? (hi_half ? '0 : a_q[step[JW-1:0]]) : msum[W-1:0];

  mm_addsub #(.W(W)) u_fold (
    .ab_w(ab_cur), .qn_w(qn_cur), .cin(cy), .n_w(n_fold), .bin(bw),
    .s_w(s_w), .cout(cout), .sn_w(sn_w), .bout(bout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; n_q <= '0; c_q <= '0; red_q <= 1'b0;
      ab_arr <= '0; q_arr <= '0; s_hi <= '0; sn_hi <= '0;
      acc_ab <= '0; acc_q <= '0; acc_qn <= '0;
      ab_cur <= '0; qn_cur <= '0; cy <= 1'b0; bw <= 1'b0;
      done_o <= 1'b0; res_o <= '0;
    end else if (accept) begin
      a_q <= in_a; b_q <= in_b; n_q <= in_n; c_q <= in_ncoef; red_q <= in_reduce;
      acc_ab <= '0; acc_q <= '0; acc_qn <= '0;
      cy <= 1'b0; bw <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= fin_last;
      if (busy) begin
        unique case (ph)
          PH_AB: if (j_last) begin
            acc_ab <= msum >> W;
            ab_cur <= ab_word;
            if (!hi_half) ab_arr[step[JW-1:0]] <= ab_word;
          end else acc_ab <= msum;
          PH_Q: if (!hi_half) begin
            if (j_last) begin
              acc_q <= msum >> W;
              q_arr[step[JW-1:0]] <= msum[W-1:0];
            end else acc_q <= msum;
          end
          PH_QN: if (j_last) begin
            acc_qn <= msum >> W;
            qn_cur <= msum[W-1:0];
          end else acc_qn <= msum;
          PH_FIN: begin
            cy <= cout;
            bw <= bout;
            if (hi_half) begin
              s_hi[hi_idx]  <= s_w;
              sn_hi[hi_idx] <= sn_w;
            end
            if (fin_last)
              res_o <= (bout && !cout) ? {s_w, s_hi[NW-2:0]} : {sn_w, sn_hi[NW-2:0]};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
  parameter int W  = 8,
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          done_o,
  input logic [NW*W-1:0] res_o
);
  localparam int LAT = 2*NW*(3*NW+1);
  logic        act;
  logic [15:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (in_valid && in_ready) begin
      act <= 1'b1;
      cnt <= '0;
    end else if (act) begin
      cnt <= cnt + 1'b1;
      if (done_o) act <= 1'b0;
    end
  end

  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_ready_while_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!act) |-> in_ready);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (act && cnt == 16'(LAT) && in_ready));
  p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_o) |-> done_o);
endmodule

bind mont_mul mm_chk #(.W(W), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done_o(done_o), .res_o(res_o)
);

// File: tb/tb_mont_mul.sv
module tb_mont_mul;
  localparam int W = 8, NW = 4, LAT = 2*NW*(3*NW+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_reduce = 1'b0;
  logic [31:0] in_a = '0, in_b = '0, in_n = '0, in_ncoef = '0;
  logic in_ready, done_o;
  logic [31:0] res_o;

  mont_mul #(.W(W), .NW(NW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_n(in_n), .in_ncoef(in_ncoef),
    .in_reduce(in_reduce), .done_o(done_o), .res_o(res_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  longint cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  longint      acc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mont(logic [31:0] a, logic [31:0] b,
                                           logic [31:0] n, bit red);
    logic [71:0] x;
    x = red ? 72'(a) : 72'(a) * 72'(b);
    for (int i = 0; i < 32; i++) begin
      if (x[0]) x = x + 72'(n);
      x = x >> 1;
    end
    if (x >= 72'(n)) x = x - 72'(n);
    return x[31:0];
  endfunction

  function automatic logic [31:0] ncoef(logic [31:0] n);
    logic [31:0] y;
    y = 32'd1;
    for (int i = 0; i < 5; i++) y = y * (32'd2 - n * y);
    return -y;
  endfunction

  task automatic send(logic [31:0] a, logic [31:0] b, logic [31:0] n, bit red, string tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_a = a; in_b = b; in_n = n; in_ncoef = ncoef(n); in_reduce = red; in_valid = 1'b1;
    exp_q.push_back(ref_mont(a, b, n, red));
    tag_q.push_back(tag);
    acc_q.push_back(cyc + 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops expected results as completions appear
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(!done_o, "R4 done pulse width", 32'(done_o), 32'd0);
      if (done_o) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected done", 32'd1, 32'd0);
        else begin
          logic [31:0] e; string t; longint a0;
          e = exp_q.pop_front(); t = tag_q.pop_front(); a0 = acc_q.pop_front();
          check(res_o === e, t, res_o, e);
          check(cyc - a0 == LAT, "R4 latency", 32'(cyc - a0), 32'(LAT));
          check(in_ready, "R4 ready with done", 32'(in_ready), 32'd1);
        end
      end
      prev_done <= done_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] n, a, b, held;
    repeat (3) @(negedge clk);
    // R6 reset state
    check(in_ready === 1'b1, "R6 in_ready", 32'(in_ready), 32'd1);
    check(done_o === 1'b0, "R6 done_o", 32'(done_o), 32'd0);
    check(res_o === 32'd0, "R6 res_o", res_o, 32'd0);
    rst_n = 1'b1;

    // Corner operands; back-to-back vectors test R7 (state cleared between)
    send(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R1 max modulus");
    send(32'd0, 32'd5, 32'hFFFF_FFFF, 1'b0, "R7 zero after max");
    send(32'd1, 32'd1, 32'h8000_0001, 1'b0, "R1 unit operands");
    send(32'd2, 32'd2, 32'd3, 1'b0, "R1 tiny modulus");
    send(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R7 repeat max");
    send(32'd1, 32'd0, 32'd3, 1'b0, "R7 small after max");
    send(32'd1, 32'hDEAD_BEEF, 32'hF000_0001, 1'b1, "R2 reduce one");
    send(32'hF000_0000, 32'h1234_5678, 32'hF000_0001, 1'b1, "R2 reduce large");
    drain();

    for (int i = 0; i < 30; i++) begin
      n = $urandom() | 32'd1;
      if (i % 3 == 0) n = n | 32'h8000_0000;
      a = $urandom() % n; b = $urandom() % n;
      send(a, b, n, 1'b0, "R1 random");
    end
    for (int i = 0; i < 8; i++) begin
      n = $urandom() | 32'h8000_0001;
      a = $urandom() % n;
      send(a, $urandom(), n, 1'b1, "R2 random reduce");
    end
    drain();

    // R3: offers made while busy are ignored
    send(32'h1234_5678, 32'h0BAD_F00D, 32'hC000_0003, 1'b0, "R3 result unaffected by busy offers");
    for (int i = 0; i < 10; i++) begin
      in_a = $urandom(); in_b = $urandom(); in_n = $urandom() | 32'd1;
      in_reduce = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      check(in_ready === 1'b0, "R3 ready low while busy", 32'(in_ready), 32'd0);
    end
    in_valid = 1'b0;
    drain();

    // R5: result holds between completions
    held = res_o;
    repeat (20) @(negedge clk);
    check(res_o === held, "R5 result held", res_o, held);
    check(in_ready === 1'b1, "R3 ready when idle", 32'(in_ready), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule